// File: doc/BRIEF.md
# Compact Bucket Metadata Packer

This block sits in the on-chip controller of a small, bandwidth-tuned oblivious memory tree whose buckets hold two data blocks. Instead of spending a whole extra memory block on per-bucket metadata, the metadata for both blocks is folded into the 128 bits that would otherwise carry two per-block error-correction codes. On a bucket write the block takes the two blocks' set and way numbers, valid flags and full leaf identifiers, the tree level, an externally computed integrity tag and the bucket's previous local counter. It steps the bucket counter and returns the packed 128-bit word, the full encryption counter and the version stamp of the path being written. On a bucket read it unpacks the word, rebuilds the full leaf identifiers and checks a 24-bit error-detection CRC over the 128 data bytes.

Leaf identifiers are kept as 9-bit suffixes. The leading bits are implied by the bucket's position on the path; near the root, the bits the path cannot supply come from an on-chip table. Bucket counters are 12 bits wide in memory. Buckets near the root get 10 more bits in an on-chip table. The encryption counter is the bucket counter placed after a global counter. When a bucket counter wraps, the global counter steps and a request to re-encrypt the whole structure is raised. A 64-bit path version counter stamps every path write. A small selector picks, among candidate correction-code copies, the one with the newest version, for use in error recovery.

Top module: `cbm_bucket_packer`

## Requirements
- R1: After reset, wr_vld, rd_vld, reenc_req, wr_word, wr_version and enc_ctr are all zero. The global counter and the version counter also start at zero, so the first write reports version 0 and a global part of 0.
- R2: A write (wr_req) gives wr_vld exactly one cycle later, with wr_word laid out as: bits 127:104 CRC, 103:68 integrity tag, 67:56 local counter, 55:28 block 1 slot, 27:0 block 0 slot. Each slot is {valid, set[13:0], way[3:0], leaf[8:0]}, most significant field first.
- R3: The CRC is CRC-24 with generator 0x864CFB and initial value 0xFFFFFF, with no final inversion, over bucket_data taken most significant bit first (byte 0 is bits 1023:1016). A read raises rd_crc_err exactly when the stored CRC field differs from the CRC of bucket_data.
- R4: The bucket counter is {side-table extension, wr_prev_ctr} for levels below 10, and wr_prev_ctr alone for deeper levels. The write stores the low 12 bits of the counter plus one. For levels below 10, the upper 10 bits go back into the extension table at that bucket's index.
- R5: When the bucket counter is all ones (22 bits near the root, 12 bits elsewhere), it wraps to zero, the global counter increments, and reenc_req is high for exactly the cycle in which wr_vld reports that write.
- R6: enc_ctr is {global counter[31:0], bucket counter[21:0]}. On a write it uses the updated values. On a read it uses the current global counter and the rebuilt bucket counter (extension plus stored field near the root, stored field elsewhere).
- R7: A read rebuilds each 16-bit leaf from three parts: the stored 9-bit suffix; the top K bits of path_leaf for a bucket at level K; and, for the high bits at positions K..6 counted from the most significant end, the side-table entry written by the last write to that bucket and slot. At level 7 and below, all 7 high bits come from path_leaf.
- R8: wr_version reports the number of earlier writes that had wr_last set. The version counter steps once after each write with wr_last.
- R9: One cycle after vsel_vers is applied, vsel_idx gives the index of the largest of the four 64-bit versions, with the lowest index winning a tie.
- R10: A read (rd_req with wr_req low) gives rd_vld one cycle later, with the valid flags, set numbers, way numbers and integrity tag taken from rd_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Pack and write one bucket |
| rd_req | input | 1 | Unpack one bucket (ignored while wr_req is high) |
| level | input | 5 | Tree level of the bucket, root = 0 |
| path_leaf | input | 16 | Leaf identifier of the path being accessed |
| wr_valid | input | 2 | Valid flag per block |
| wr_set | input | 2x14 | Set number per block |
| wr_way | input | 2x4 | Way number per block |
| wr_leaf | input | 2x16 | Full leaf identifier per block |
| wr_tag | input | 36 | Integrity tag for the bucket |
| wr_prev_ctr | input | 12 | Local counter read earlier from this bucket |
| wr_last | input | 1 | This write ends a path write |
| bucket_data | input | 1024 | The bucket's two data blocks |
| rd_word | input | 128 | Packed metadata word to unpack |
| vsel_vers | input | 4x64 | Candidate version numbers |
| wr_vld | output | 1 | Write result valid |
| wr_word | output | 128 | Packed metadata word |
| wr_version | output | 64 | Version stamp for the path |
| reenc_req | output | 1 | Re-encryption request pulse |
| enc_ctr | output | 54 | Full encryption counter |
| rd_vld | output | 1 | Read result valid |
| rd_valid | output | 2 | Unpacked valid flags |
| rd_set | output | 2x14 | Unpacked set numbers |
| rd_way | output | 2x4 | Unpacked way numbers |
| rd_leaf | output | 2x16 | Rebuilt leaf identifiers |
| rd_tag | output | 36 | Unpacked integrity tag |
| rd_crc_err | output | 1 | Stored CRC does not match the data |
| vsel_idx | output | 2 | Index of the newest version |

## Verification
The assertions assume that wr_req and rd_req are never high together. They also assume that each block's leaf shares its top K bits with path_leaf, as the tree invariant demands, because the rebuild step relies on that. The bench drives one request at a time and forms every leaf by masking path_leaf's top K bits into otherwise random values. Reads reuse the level, path and data of the write they follow, and data bits are flipped on purpose only to trigger CRC errors.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CRC_W  = 24;
  localparam int TAG_W  = 36;
  localparam int LCTR_W = 12;
  localparam int EXT_W  = 10;
  localparam int SET_W  = 14;
  localparam int WAY_W  = 4;
  localparam int SUF_W  = 9;
  localparam int VER_W  = 64;
  localparam int WORD_W = 128;
  localparam int BCTR_W = LCTR_W + EXT_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 24'h864CFB;
  localparam logic [CRC_W-1:0] CRC_INIT = 24'hFFFFFF;

  typedef struct packed {
    logic             valid;
    logic [SET_W-1:0] set_no;
    logic [WAY_W-1:0] way_no;
    logic [SUF_W-1:0] suffix;
  } slot_t;

  typedef struct packed {
    logic [CRC_W-1:0]  crc;
    logic [TAG_W-1:0]  tag;
    logic [LCTR_W-1:0] lctr;
    slot_t             s1;
    slot_t             s0;
  } word_t;
endpackage

// File: rtl/cbm_crc24.sv
module cbm_crc24 import cbm_pkg::*; #(
  parameter int NBYTES = 128
) (
  input  logic [NBYTES*8-1:0] din,
  output logic [CRC_W-1:0]    crc
);
  function automatic logic [CRC_W-1:0] crc_bits(input logic [NBYTES*8-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = CRC_INIT;
    for (int i = NBYTES*8-1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  assign crc = crc_bits(din);
endmodule

// File: rtl/cbm_side_table.sv
module cbm_side_table #(
  parameter int AW    = 10,
  parameter int WIDTH = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cbm_version_pick.sv
module cbm_version_pick #(
  parameter int NCAND = 4,
  parameter int VW    = 64,
  localparam int SEL_W = $clog2(NCAND)
) (
  input  logic [NCAND-1:0][VW-1:0] vers,
  output logic [SEL_W-1:0]         sel
);
  logic [VW-1:0] best;

  always_comb begin
    sel  = '0;
    best = vers[0];
    for (int i = 1; i < NCAND; i++) begin
      if (vers[i] > best) begin
        best = vers[i];
        sel  = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/cbm_bucket_packer.sv
module cbm_bucket_packer import cbm_pkg::*; #(
  parameter int LEAF_W     = 16,
  parameter int TOP_LEVELS = 10,
  parameter int DATA_BYTES = 128,
  parameter int GCTR_W     = 32,
  parameter int NCAND      = 4,
  localparam int LVL_W = $clog2(LEAF_W + 1),
  localparam int HI_W  = LEAF_W - SUF_W,
  localparam int ENC_W = GCTR_W + BCTR_W,
  localparam int SEL_W = $clog2(NCAND)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_req,
  input  logic                        rd_req,
  input  logic [LVL_W-1:0]            level,
  input  logic [LEAF_W-1:0]           path_leaf,
  input  logic [1:0]                  wr_valid,
  input  logic [1:0][SET_W-1:0]       wr_set,
  input  logic [1:0][WAY_W-1:0]       wr_way,
  input  logic [1:0][LEAF_W-1:0]      wr_leaf,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [LCTR_W-1:0]           wr_prev_ctr,
  input  logic                        wr_last,
  input  logic [DATA_BYTES*8-1:0]     bucket_data,
  input  logic [WORD_W-1:0]           rd_word,
  input  logic [NCAND-1:0][VER_W-1:0] vsel_vers,
  output logic                        wr_vld,
  output logic [WORD_W-1:0]           wr_word,
  output logic [VER_W-1:0]            wr_version,
  output logic                        reenc_req,
  output logic [ENC_W-1:0]            enc_ctr,
  output logic                        rd_vld,
  output logic [1:0]                  rd_valid,
  output logic [1:0][SET_W-1:0]       rd_set,
  output logic [1:0][WAY_W-1:0]       rd_way,
  output logic [1:0][LEAF_W-1:0]      rd_leaf,
  output logic [TAG_W-1:0]            rd_tag,
  output logic                        rd_crc_err,
  output logic [SEL_W-1:0]            vsel_idx
);

  // bucket index inside the heap-ordered top of the tree
  function automatic logic [TOP_LEVELS-1:0] bucket_idx(input logic [LVL_W-1:0] k,
                                                        input logic [LEAF_W-1:0] leaf);
    logic [31:0] base, off;
    base = (32'd1 << k) - 32'd1;
    off  = 32'(leaf) >> (LEAF_W - int'(k));
    return TOP_LEVELS'(base + off);
  endfunction

  // high bits: first K from the path, the rest from the side table
  function automatic logic [LEAF_W-1:0] rebuild_leaf(input logic [LVL_W-1:0] k,
                                                      input logic [LEAF_W-1:0] path,
                                                      input logic [HI_W-1:0] tab,
                                                      input logic [SUF_W-1:0] suf);
    logic [LEAF_W-1:0] r;
    r[SUF_W-1:0] = suf;
    for (int j = 0; j < HI_W; j++)
      r[LEAF_W-1-j] = (j < int'(k)) ? path[LEAF_W-1-j] : tab[HI_W-1-j];
    return r;
  endfunction

  // named internal events for the assertions
  logic                    is_top, is_hi, ctr_wrap, pick_ok;
  logic [TOP_LEVELS-1:0]   bidx;
  logic [EXT_W-1:0]        ext_rd;
  logic [1:0][HI_W-1:0]    hi_rd;
  logic [CRC_W-1:0]        crc_now;
  logic [BCTR_W-1:0]       bctr_old, bctr_new, bctr_rd;
  logic [GCTR_W-1:0]       gctr, gctr_next;
  logic [VER_W-1:0]        ver_q;
  logic [SEL_W-1:0]        pick_sel;
  word_t                   wpack, rw;

  assign is_top = int'(level) < TOP_LEVELS;
  assign is_hi  = int'(level) < HI_W;
  assign bidx   = bucket_idx(level, path_leaf);
  assign rw     = word_t'(rd_word);

  cbm_crc24 #(.NBYTES(DATA_BYTES)) u_crc (.din(bucket_data), .crc(crc_now));

  cbm_side_table #(.AW(TOP_LEVELS), .WIDTH(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .we(wr_req && is_top), .waddr(bidx),
    .wdata(bctr_new[BCTR_W-1:LCTR_W]), .raddr(bidx), .rdata(ext_rd));

  for (genvar s = 0; s < 2; s++) begin : g_hi
    cbm_side_table #(.AW(HI_W), .WIDTH(HI_W)) u_hi (
      .clk(clk), .rst_n(rst_n), .we(wr_req && is_hi), .waddr(bidx[HI_W-1:0]),
      .wdata(wr_leaf[s][LEAF_W-1:SUF_W]), .raddr(bidx[HI_W-1:0]), .rdata(hi_rd[s]));
  end

  cbm_version_pick #(.NCAND(NCAND), .VW(VER_W)) u_pick (.vers(vsel_vers), .sel(pick_sel));

  // counter step and wrap
  always_comb begin
    bctr_old  = is_top ? {ext_rd, wr_prev_ctr} : {{EXT_W{1'b0}}, wr_prev_ctr};
    ctr_wrap  = is_top ? (&bctr_old) : (&wr_prev_ctr);
    bctr_new  = ctr_wrap ? '0 : bctr_old + 1'b1;
    gctr_next = gctr + GCTR_W'(ctr_wrap);
    bctr_rd   = is_top ? {ext_rd, rw.lctr} : {{EXT_W{1'b0}}, rw.lctr};
  end

  // write packing
  always_comb begin
    wpack.crc       = crc_now;
    wpack.tag       = wr_tag;
    wpack.lctr      = bctr_new[LCTR_W-1:0];
    wpack.s0.valid  = wr_valid[0];
    wpack.s0.set_no = wr_set[0];
    wpack.s0.way_no = wr_way[0];
    wpack.s0.suffix = wr_leaf[0][SUF_W-1:0];
    wpack.s1.valid  = wr_valid[1];
    wpack.s1.set_no = wr_set[1];
    wpack.s1.way_no = wr_way[1];
    wpack.s1.suffix = wr_leaf[1][SUF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_vld <= 1'b0; rd_vld <= 1'b0; reenc_req <= 1'b0;
      wr_word <= '0; wr_version <= '0; enc_ctr <= '0;
      gctr <= '0; ver_q <= '0; vsel_idx <= '0;
      rd_valid <= '0; rd_set <= '0; rd_way <= '0; rd_leaf <= '0;
      rd_tag <= '0; rd_crc_err <= 1'b0;
    end else begin
      wr_vld    <= wr_req;
      rd_vld    <= rd_req && !wr_req;
      reenc_req <= wr_req && ctr_wrap;
      vsel_idx  <= pick_sel;
      if (wr_req) begin
        wr_word    <= wpack;
        gctr       <= gctr_next;
        enc_ctr    <= {gctr_next, bctr_new};
        wr_version <= ver_q;
        if (wr_last) ver_q <= ver_q + 1'b1;
      end else if (rd_req) begin
        rd_valid   <= {rw.s1.valid, rw.s0.valid};
        rd_set     <= {rw.s1.set_no, rw.s0.set_no};
        rd_way     <= {rw.s1.way_no, rw.s0.way_no};
        rd_leaf[0] <= rebuild_leaf(level, path_leaf, hi_rd[0], rw.s0.suffix);
        rd_leaf[1] <= rebuild_leaf(level, path_leaf, hi_rd[1], rw.s1.suffix);
        rd_tag     <= rw.tag;
        rd_crc_err <= rw.crc != crc_now;
        enc_ctr    <= {gctr, bctr_rd};
      end
    end
  end

  // tie-aware check of the picker: nothing larger, nothing equal earlier
  always_comb begin
    pick_ok = 1'b1;
    for (int i = 0; i < NCAND; i++) begin
      if (vsel_vers[i] > vsel_vers[pick_sel]) pick_ok = 1'b0;
      if (i < int'(pick_sel) && vsel_vers[i] == vsel_vers[pick_sel]) pick_ok = 1'b0;
    end
  end

  p_wr_latency_r2: assert property (@(posedge clk) disable iff (!rst_n) wr_req |=> wr_vld);
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_req) |=> rd_vld);
  p_gctr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reenc_req |-> gctr == $past(gctr) + 1'b1);
  p_gctr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reenc_req |-> gctr == $past(gctr));
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reenc_req |-> (wr_vld && wr_word[67:56] == '0));
  p_ver_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_last) |=> ver_q == $past(ver_q) + 1'b1);
  p_ver_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && wr_last) |=> $stable(ver_q));
  p_pick_max_r9: assert property (@(posedge clk) disable iff (!rst_n) pick_ok);
endmodule

// File: tb/cbm_bucket_packer_test.sv
`timescale 1ns/1ps
module cbm_bucket_packer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic wr_req = 0, rd_req = 0, wr_last = 0;
  logic [4:0] level = 0;
  logic [15:0] path_leaf = 0;
  logic [1:0] wr_valid = 0;
  logic [1:0][13:0] wr_set = '0;
  logic [1:0][3:0] wr_way = '0;
  logic [1:0][15:0] wr_leaf = '0;
  logic [35:0] wr_tag = 0;
  logic [11:0] wr_prev_ctr = 0;
  logic [1023:0] bucket_data = '0;
  logic [127:0] rd_word = '0;
  logic [3:0][63:0] vsel_vers = '0;
  logic wr_vld, reenc_req, rd_vld, rd_crc_err;
  logic [127:0] wr_word;
  logic [63:0] wr_version;
  logic [53:0] enc_ctr;
  logic [1:0] rd_valid;
  logic [1:0][13:0] rd_set;
  logic [1:0][3:0] rd_way;
  logic [1:0][15:0] rd_leaf;
  logic [35:0] rd_tag;
  logic [1:0] vsel_idx;

  cbm_bucket_packer uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [127:0] word; logic [63:0] ver; logic reenc; logic [53:0] enc; } wexp_t;
  typedef struct { logic [1:0] v; logic [1:0][13:0] s; logic [1:0][3:0] w;
                   logic [1:0][15:0] l; logic [35:0] tag; logic [53:0] enc; logic err; } rexp_t;
  wexp_t wq[$];
  rexp_t rq[$];

  // bench model state
  logic [31:0] g_m = 0;
  logic [63:0] v_m = 0;
  int ext_m[int];
  int hi_m[int];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[30:16], seed[15:0] ^ seed[31:16], 1'b0} ^ (seed >> 7);
  endfunction

  function automatic logic [23:0] ref_crc(input logic [1023:0] d);
    logic [23:0] c;
    c = 24'hFFFFFF;
    for (int b = 0; b < 128; b++) begin
      c = c ^ {d[1023-8*b -: 8], 16'h0};
      for (int k = 0; k < 8; k++) c = c[23] ? ((c << 1) ^ 24'h864CFB) : (c << 1);
    end
    return c;
  endfunction

  function automatic int ref_idx(input int k, input logic [15:0] p);
    return ((1 << k) | (int'(p) >> (16 - k))) - 1;
  endfunction

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int k, input logic [15:0] p, input logic [1:0] v,
                          input logic [1:0][13:0] s, input logic [1:0][3:0] w,
                          input logic [1:0][15:0] l, input logic [35:0] tag,
                          input logic [11:0] prev, input logic last,
                          input logic [1023:0] d, output logic [127:0] word);
    wexp_t e;
    int idx, ext;
    logic [21:0] old, nw;
    logic wrap;
    idx = ref_idx(k, p);
    ext = (k < 10 && ext_m.exists(idx)) ? ext_m[idx] : 0;
    old = (k < 10) ? {ext[9:0], prev} : {10'h0, prev};
    wrap = (k < 10) ? (old == 22'h3FFFFF) : (prev == 12'hFFF);
    nw = wrap ? 22'h0 : old + 22'd1;
    if (k < 10) ext_m[idx] = int'(nw[21:12]);
    if (wrap) g_m = g_m + 1;
    if (k < 7) for (int sl = 0; sl < 2; sl++) hi_m[sl*1024 + idx] = int'(l[sl][15:9]);
    word = {ref_crc(d), tag, nw[11:0], v[1], s[1], w[1], l[1][8:0], v[0], s[0], w[0], l[0][8:0]};
    e.word = word; e.ver = v_m; e.reenc = wrap; e.enc = {g_m, nw};
    if (last) v_m = v_m + 1;
    @(negedge clk);
    level = 5'(k); path_leaf = p; wr_valid = v; wr_set = s; wr_way = w; wr_leaf = l;
    wr_tag = tag; wr_prev_ctr = prev; wr_last = last; bucket_data = d; wr_req = 1;
    wq.push_back(e);
    @(negedge clk);
    wr_req = 0;
  endtask

  task automatic do_read(input int k, input logic [15:0] p, input logic [127:0] word,
                         input logic [1023:0] d);
    rexp_t e;
    int idx, ext, tab;
    logic [6:0] kmask, hi;
    logic [21:0] bc;
    idx = ref_idx(k, p);
    ext = (k < 10 && ext_m.exists(idx)) ? ext_m[idx] : 0;
    bc = (k < 10) ? {ext[9:0], word[67:56]} : {10'h0, word[67:56]};
    for (int sl = 0; sl < 2; sl++) begin
      logic [27:0] sf;
      sf = word[28*sl +: 28];
      e.v[sl] = sf[27]; e.s[sl] = sf[26:13]; e.w[sl] = sf[12:9];
      if (k >= 7) hi = p[15:9];
      else begin
        tab = hi_m.exists(sl*1024 + idx) ? hi_m[sl*1024 + idx] : 0;
        kmask = 7'(((1 << k) - 1) << (7 - k));
        hi = (p[15:9] & kmask) | (tab[6:0] & ~kmask);
      end
      e.l[sl] = {hi, sf[8:0]};
    end
    e.tag = word[103:68]; e.enc = {g_m, bc}; e.err = (ref_crc(d) != word[127:104]);
    @(negedge clk);
    level = 5'(k); path_leaf = p; rd_word = word; bucket_data = d; rd_req = 1;
    rq.push_back(e);
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic do_pick(input logic [3:0][63:0] vv, input logic [1:0] exp, input string what);
    @(negedge clk);
    vsel_vers = vv;
    @(negedge clk);
    chk("R9", what, 128'(vsel_idx), 128'(exp));
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_vld) begin
        if (wq.size() == 0) chk("R2", "unexpected wr_vld", 1, 0);
        else begin
          wexp_t e;
          e = wq.pop_front();
          chk("R3", "crc field", 128'(wr_word[127:104]), 128'(e.word[127:104]));
          chk("R2", "tag and slots", {wr_word[103:68], wr_word[55:0]}, {e.word[103:68], e.word[55:0]});
          chk("R4", "local counter", 128'(wr_word[67:56]), 128'(e.word[67:56]));
          chk("R8", "version", 128'(wr_version), 128'(e.ver));
          chk("R5", "reenc_req", 128'(reenc_req), 128'(e.reenc));
          chk("R6", "write enc_ctr", 128'(enc_ctr), 128'(e.enc));
        end
      end else chk("R5", "reenc without write", 128'(reenc_req), 0);
      if (rd_vld) begin
        if (rq.size() == 0) chk("R10", "unexpected rd_vld", 1, 0);
        else begin
          rexp_t e;
          e = rq.pop_front();
          chk("R10", "valid/set/way", {rd_valid, rd_set, rd_way}, {e.v, e.s, e.w});
          chk("R10", "tag", 128'(rd_tag), 128'(e.tag));
          chk("R7", "leaves", 128'(rd_leaf), 128'(e.l));
          chk("R3", "crc error", 128'(rd_crc_err), 128'(e.err));
          chk("R6", "read enc_ctr", 128'(enc_ctr), 128'(e.enc));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [127:0] w;
    logic [1023:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset valids", {wr_vld, rd_vld, reenc_req}, 0);
    chk("R1", "reset word", wr_word, 0);
    chk("R1", "reset version/enc", {wr_version, enc_ctr}, 0);

    for (int i = 0; i < 32; i++) d[i*32 +: 32] = rnd();
    // level 12: high bits from path, first write version 0
    do_write(12, 16'hA5C3, 2'b11, {14'h0123, 14'h1ABC}, {4'h2, 4'h9}, {16'hA5CF, 16'hA5C7},
             36'h987654321, 12'h123, 0, d, w);
    do_read(12, 16'hA5C3, w, d);
    do_read(12, 16'hA5C3, w, d ^ 1024'h1);            // R3 corrupted data
    // level 3: carry into extension, no wrap (R4/R5 boundary), ends a path
    do_write(3, 16'h3F00, 2'b10, {14'h3FFF, 14'h0001}, {4'hF, 4'h0}, {16'h3123, 16'h2ABC},
             36'h0F0F0F0F0, 12'hFFF, 1, d, w);
    do_read(3, 16'h3F00, w, d);
    // level 12 wrap: global counter steps, reenc pulse
    do_write(12, 16'hA5C3, 2'b01, {14'h0, 14'h2222}, {4'h1, 4'h3}, {16'hA5C0, 16'hA5C1},
             36'h1, 12'hFFF, 0, d, w);
    // root: every high bit from the side table
    do_write(0, 16'h0000, 2'b01, {14'h0005, 14'h0006}, {4'h7, 4'h8}, {16'h1234, 16'hFFFF},
             36'hABCDEF012, 12'h000, 1, d, w);
    do_read(0, 16'h0000, w, d);
    // boundary levels 6 and 7
    do_write(6, 16'h8421, 2'b11, {14'h0A0A, 14'h0B0B}, {4'h4, 4'h5}, {16'h8600, 16'h85FF},
             36'h5, 12'h010, 0, d, w);
    do_read(6, 16'h8421, w, d);
    do_write(7, 16'h8421, 2'b11, {14'h0C0C, 14'h0D0D}, {4'h6, 4'hA}, {16'h8401, 16'h85FE},
             36'h6, 12'h020, 1, d, w);
    do_read(7, 16'h8421, w, d);

    // randomized pattern sweep
    for (int it = 0; it < 30; it++) begin
      int k;
      logic [15:0] p, hm;
      logic [1:0][15:0] l;
      logic [11:0] prev;
      logic [1023:0] dd;
      k = int'(rnd() % 17);
      p = rnd()[15:0];
      hm = (k == 0) ? 16'h0 : 16'(16'hFFFF << (16 - k));
      for (int sl = 0; sl < 2; sl++) l[sl] = (p & hm) | (rnd()[15:0] & ~hm);
      prev = (it % 5 == 4) ? 12'hFFF : rnd()[11:0];
      for (int i = 0; i < 32; i++) dd[i*32 +: 32] = rnd();
      do_write(k, p, rnd()[1:0], {rnd()[13:0], rnd()[13:0]}, {rnd()[3:0], rnd()[3:0]}, l,
               {rnd()[3:0], rnd()}, prev, (it % 4 == 3), dd, w);
      do_read(k, p, w, (it % 3 == 2) ? (dd ^ (1024'h1 << (it * 31))) : dd);
    end

    do_pick({64'd2, 64'd9, 64'd9, 64'd5}, 2'd1, "tie picks lower");
    do_pick({64'd0, 64'd0, 64'd0, 64'd0}, 2'd0, "all equal");
    do_pick({64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd2, 64'd1}, 2'd3, "max at top index");
    do_pick({64'd3, 64'd7, 64'd1, 64'd7}, 2'd0, "tie at ends");

    repeat (3) @(negedge clk);
    chk("R2", "write queue drained", 128'(wq.size()), 0);
    chk("R10", "read queue drained", 128'(rq.size()), 0);
    finish_run();
  end
endmodule